// File: doc/BRIEF.md
# Attribute-Typed Configuration Register Bank

This block is a small bank of host-visible configuration words. Each bit carries one of several fixed access rules: plain read/write, read-only, write-one-to-clear status, or write-once lock. Bits outside these classes are reserved. The host drives a single-cycle read or write strobe with a word address, a 32-bit data bus and four byte enables. A single-byte, half-word or full-word access is formed by choosing which byte lanes are enabled.

Two resets act on the bank. A power-good reset is asynchronous and active-low, and its release is synchronised inside the block. It returns every bit and every write-once flag to its elaboration value. A soft reset is a synchronous active-low input. It restores only the bits that are not marked sticky, so error-logging bits survive it. Hardware event inputs set the write-one-to-clear bits.

With the default parameters the bank holds four words:
- Word 0 is an address pointer. Bits 31..2 are read/write and bits 1..0 are reserved.
- Word 1 is a control word. Bits 7..0 are read/write. Bits 15..8 are read-only and hold 0xA5. Bits 23..16 are write-once and sticky. Bits 31..24 are reserved and hold 0x3C.
- Word 2 is a status word. Bits 15..0 are write-one-to-clear, with bits 15..8 sticky. Bits 31..16 are read/write, with bits 31..24 sticky.
- Word 3 is a read-only identifier that holds 0x12345678.

Top module: `cfgbank_top`

## Requirements
- R1: Byte lane k (k = 0..3) carries bits 8k+7..8k of the addressed word, which is little-endian order. A write changes only the lanes whose byte enable is 1.
- R2: A read/write bit takes the written value in an enabled lane, and the next read returns that value.
- R3: Read-only and reserved bits ignore all writes and always read their elaboration value. For word 1 this is 0xA5 in bits 15..8 and 0x3C in bits 31..24. Word 3 reads 0x12345678.
- R4: On a write-one-to-clear bit in an enabled lane, writing 1 clears the bit and writing 0 leaves it unchanged.
- R5: A 1 on a hardware event input sets the matching write-one-to-clear bit. When an event and a host clear hit the same bit in the same cycle, the bit ends up set.
- R6: The first write that enables a write-once bit's lane stores the data and marks the bit as written. Any later write to that bit is ignored until a power-good reset.
- R7: A soft reset returns all non-sticky bits to their elaboration values. Sticky bits keep their values, and write-once flags survive the soft reset.
- R8: After a power-good reset every word reads its elaboration value, every write-once flag is cleared, and rdata and rvalid are 0.
- R9: The pointer word (address 0) accepts a write only when the byte enables are 4'hF. A read of the pointer word with narrower enables returns 0.
- R10: rvalid is 1 in the cycle after a read strobe and 0 otherwise. rdata holds the addressed word in that cycle, with disabled lanes read as 0. In cycles without a read, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pg_rst_n | input | 1 | Power-good reset, asynchronous, active-low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active-low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Word address |
| be | input | 4 | Byte enables, one per lane |
| wdata | input | 32 | Write data |
| evt_set | input | NUM_REGS*32 | Hardware set inputs, one per bit of every word |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid |

## Verification
Nearly all internal state can be read back, so a wrong bit value shows up in rdata one cycle after the next read of its word. The exception is the write-once flag. A flag that is wrongly clear shows only when a second write changes a locked value, which is visible on the read that follows. A flag that is wrongly set shows when a first write fails to take effect. A bench reference model is compared on every read in a long random mix of accesses, events and soft resets. This catches a wrong attribute or a wrong reset class within a few operations of the access that exposes it.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int DW   = 32;
  localparam int BE_W = DW / 8;

  // expand byte enables into a per-bit lane mask (lane k -> bits 8k+7..8k)
  function automatic logic [DW-1:0] lane_mask(input logic [BE_W-1:0] be);
    logic [DW-1:0] m;
    for (int k = 0; k < BE_W; k++) m[k*8 +: 8] = {8{be[k]}};
    return m;
  endfunction
endpackage

// File: rtl/cfgbank_rst_sync.sv
module cfgbank_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
  import cfgbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int AW       = 2,
  parameter int PTR_IDX  = 0
) (
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [BE_W-1:0]     be,
  output logic [NUM_REGS-1:0] we_vec,
  output logic                rd_ok,
  output logic [DW-1:0]       bmask
);
  logic in_range, ptr_hit, full_word, legal;

  always_comb begin
    in_range  = int'(addr) < NUM_REGS;
    ptr_hit   = int'(addr) == PTR_IDX;
    full_word = &be;
    legal     = in_range && !(ptr_hit && !full_word);
    rd_ok     = rd_en && legal;
    bmask     = lane_mask(be);
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
    assign we_vec[i] = wr_en && legal && (int'(addr) == i);
  end
endmodule

// File: rtl/cfgbank_word.sv
module cfgbank_word
  import cfgbank_pkg::*;
#(
  parameter logic [DW-1:0] RW_MASK  = '0,
  parameter logic [DW-1:0] W1C_MASK = '0,
  parameter logic [DW-1:0] LCK_MASK = '0,
  parameter logic [DW-1:0] STK_MASK = '0,
  parameter logic [DW-1:0] RST_VAL  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst_n,
  input  logic          we,
  input  logic [DW-1:0] bmask,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] FIXED = ~(RW_MASK | W1C_MASK | LCK_MASK);

  logic [DW-1:0] q_q, q_d, flag_q, flag_d, hit, lk_en;
  logic          upd;

  always_comb begin
    hit   = we ? bmask : '0;
    lk_en = hit & LCK_MASK & ~flag_q;
    upd   = !soft_rst_n || we || |(evt & W1C_MASK);
    if (!soft_rst_n) begin
      q_d    = (STK_MASK & q_q) | (~STK_MASK & RST_VAL);
      flag_d = flag_q;
    end else begin
      q_d    = (RW_MASK  & ((q_q & ~hit) | (wdata & hit)))
             | (W1C_MASK & ((q_q & ~(wdata & hit)) | evt))
             | (LCK_MASK & ((q_q & ~lk_en) | (wdata & lk_en)))
             | (FIXED    & RST_VAL);
      flag_d = flag_q | lk_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= RST_VAL;
      flag_q <= '0;
    end else if (upd) begin
      q_q    <= q_d;
      flag_q <= flag_d;
    end
  end

  assign q = q_q;

  // a written lock bit never changes again
  assert_lock_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q_q ^ $past(q_q)) & LCK_MASK & $past(flag_q)) == '0));

  // event set dominates a same-cycle host clear
  assert_evt_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_n |=> ((~q_q & $past(evt) & W1C_MASK) == '0));

  // sticky bits survive a soft reset
  assert_sticky_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_n |=> (((q_q ^ $past(q_q)) & STK_MASK) == '0));
endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux
  import cfgbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int AW       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic                   rd_ok,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          bmask,
  input  logic [NUM_REGS*DW-1:0] words,
  output logic [DW-1:0]          rdata,
  output logic                   rvalid
);
  logic [DW-1:0] sel, rdata_d;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(addr) == i) sel = words[i*DW +: DW];
    rdata_d = rd_ok ? (sel & bmask) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rdata_d;
      rvalid <= rd_en;
    end
  end

  assert_rvalid_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rvalid && rdata == '0));
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int PTR_IDX  = 0,
  parameter logic [NUM_REGS*32-1:0] RW_MASK  =
    {32'h0000_0000, 32'hFFFF_0000, 32'h0000_00FF, 32'hFFFF_FFFC},
  parameter logic [NUM_REGS*32-1:0] W1C_MASK =
    {32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000},
  parameter logic [NUM_REGS*32-1:0] LCK_MASK =
    {32'h0000_0000, 32'h0000_0000, 32'h00FF_0000, 32'h0000_0000},
  parameter logic [NUM_REGS*32-1:0] STK_MASK =
    {32'h0000_0000, 32'hFF00_FF00, 32'h00FF_0000, 32'h0000_0000},
  parameter logic [NUM_REGS*32-1:0] RST_VAL  =
    {32'h1234_5678, 32'h0000_0000, 32'h3C00_A500, 32'h0000_0000},
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   pg_rst_n,
  input  logic                   soft_rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  input  logic [NUM_REGS*32-1:0] evt_set,
  output logic [31:0]            rdata,
  output logic                   rvalid
);
  logic                   rst_n;
  logic [NUM_REGS-1:0]    we_vec;
  logic                   rd_ok;
  logic [DW-1:0]          bmask;
  logic [NUM_REGS*DW-1:0] words;

  cfgbank_rst_sync u_rst (.clk(clk), .arst_n(pg_rst_n), .rst_n(rst_n));

  cfgbank_decode #(.NUM_REGS(NUM_REGS), .AW(AW), .PTR_IDX(PTR_IDX)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .be(be),
    .we_vec(we_vec), .rd_ok(rd_ok), .bmask(bmask)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    cfgbank_word #(
      .RW_MASK (RW_MASK [i*DW +: DW]),
      .W1C_MASK(W1C_MASK[i*DW +: DW]),
      .LCK_MASK(LCK_MASK[i*DW +: DW]),
      .STK_MASK(STK_MASK[i*DW +: DW]),
      .RST_VAL (RST_VAL [i*DW +: DW])
    ) u_word (
      .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
      .we(we_vec[i]), .bmask(bmask), .wdata(wdata),
      .evt(evt_set[i*DW +: DW]), .q(words[i*DW +: DW])
    );
  end

  cfgbank_rdmux #(.NUM_REGS(NUM_REGS), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ok(rd_ok), .addr(addr),
    .bmask(bmask), .words(words), .rdata(rdata), .rvalid(rvalid)
  );

  // a narrow write to the pointer word leaves it untouched
  assert_ptr_narrow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == PTR_IDX && be != 4'hF && soft_rst_n &&
     evt_set[PTR_IDX*DW +: DW] == '0)
    |=> $stable(words[PTR_IDX*DW +: DW]));
endmodule

// File: tb/sim_cfgbank_top.sv
module sim_cfgbank_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] RWM [4] = '{32'hFFFF_FFFC, 32'h0000_00FF, 32'hFFFF_0000, 32'h0};
  localparam logic [31:0] W1M [4] = '{32'h0, 32'h0, 32'h0000_FFFF, 32'h0};
  localparam logic [31:0] LKM [4] = '{32'h0, 32'h00FF_0000, 32'h0, 32'h0};
  localparam logic [31:0] STM [4] = '{32'h0, 32'h00FF_0000, 32'hFF00_FF00, 32'h0};
  localparam logic [31:0] RSV [4] = '{32'h0, 32'h3C00_A500, 32'h0, 32'h1234_5678};

  logic         clk = 1'b0;
  logic         pg_rst_n = 1'b0;
  logic         soft_rst_n = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [3:0]   be = '0;
  logic [31:0]  wdata = '0;
  logic [127:0] evt_set = '0;
  logic [31:0]  rdata;
  logic         rvalid;

  int n_cmp = 0;
  int n_bad = 0;
  int n_cyc = 0;
  logic [31:0] mreg [4];
  logic [31:0] mflg [4];

  cfgbank_top u0 (
    .clk(clk), .pg_rst_n(pg_rst_n), .soft_rst_n(soft_rst_n), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .be(be), .wdata(wdata), .evt_set(evt_set),
    .rdata(rdata), .rvalid(rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", n_cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] lanes(input logic [3:0] b);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[k*8 +: 8] = {8{b[k]}};
    return m;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      mreg[i] = RSV[i];
      mflg[i] = '0;
    end
  endtask

  // one bus cycle; returns read data and the model's expectation
  task automatic cyc(input logic w, input logic r, input int a, input logic [3:0] b,
                     input logic [31:0] d, input logic [127:0] ev, input logic s,
                     output logic [31:0] got, output logic [31:0] mexp,
                     output logic gotv);
    logic        legal;
    logic [31:0] hit, lk, nv;
    legal = (a != 0) || (b == 4'hF);
    mexp  = (r && legal) ? (mreg[a] & lanes(b)) : 32'h0;
    wr_en = w; rd_en = r; addr = a[1:0]; be = b; wdata = d; evt_set = ev; soft_rst_n = s;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (!s) begin
        nv = (STM[i] & mreg[i]) | (~STM[i] & RSV[i]);
      end else begin
        hit = (w && legal && a == i) ? lanes(b) : 32'h0;
        lk  = hit & LKM[i] & ~mflg[i];
        nv  = (RWM[i] & ((mreg[i] & ~hit) | (d & hit)))
            | (W1M[i] & ((mreg[i] & ~(d & hit)) | ev[i*32 +: 32]))
            | (LKM[i] & ((mreg[i] & ~lk) | (d & lk)))
            | (~(RWM[i] | W1M[i] | LKM[i]) & RSV[i]);
        mflg[i] = mflg[i] | lk;
      end
      mreg[i] = nv;
    end
    @(negedge clk);
    got = rdata; gotv = rvalid;
    wr_en = 0; rd_en = 0; evt_set = '0; soft_rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input logic [3:0] b, input logic [31:0] d,
                    input logic [127:0] ev);
    logic [31:0] g, e; logic v;
    cyc(1'b1, 1'b0, a, b, d, ev, 1'b1, g, e, v);
  endtask

  task automatic rd(input int a, input logic [3:0] b, input logic [31:0] exp,
                    input string tag);
    logic [31:0] g, e; logic v;
    cyc(1'b0, 1'b1, a, b, 32'h0, '0, 1'b1, g, e, v);
    chk(tag, g, exp);
    chk("R10 rvalid", {31'h0, v}, 32'h1);
  endtask

  task automatic pg_reset();
    @(negedge clk);
    pg_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    pg_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  initial begin
    logic [31:0] g, e; logic v;
    logic [3:0] bsel [8] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF, 4'hF};
    void'($urandom(32'd7719));
    pg_reset();

    // R8: reset state
    chk("R8 rdata", rdata, 32'h0);
    chk("R8 rvalid", {31'h0, rvalid}, 32'h0);
    rd(0, 4'hF, 32'h0000_0000, "R8 word0");
    rd(1, 4'hF, 32'h3C00_A500, "R3 word1");
    rd(2, 4'hF, 32'h0000_0000, "R8 word2");
    rd(3, 4'hF, 32'h1234_5678, "R3 word3");

    // R10: idle cycle after a read
    cyc(1'b0, 1'b0, 0, 4'h0, 32'h0, '0, 1'b1, g, e, v);
    chk("R10 idle rvalid", {31'h0, v}, 32'h0);
    chk("R10 idle rdata", g, 32'h0);

    // R1 / R3: single byte write, read-only byte untouched
    wr(1, 4'h1, 32'hEEEE_EE77, '0);
    rd(1, 4'hF, 32'h3C00_A577, "R1 byte0");
    rd(1, 4'h2, 32'h0000_A500, "R10 lane mask");
    // R6: first lock write stores, later ignored
    wr(1, 4'h4, 32'h00AB_0000, '0);
    rd(1, 4'hF, 32'h3CAB_A577, "R6 first");
    wr(1, 4'hF, 32'hFFCD_0011, '0);
    rd(1, 4'hF, 32'h3CAB_A511, "R6 second");

    // R9: pointer word
    wr(0, 4'h3, 32'h0000_1234, '0);
    rd(0, 4'hF, 32'h0000_0000, "R9 narrow write");
    wr(0, 4'hF, 32'hDEAD_BEEF, '0);
    rd(0, 4'h3, 32'h0000_0000, "R9 narrow read");
    rd(0, 4'hF, 32'hDEAD_BEEC, "R9 full");

    // R4 / R5: status bits
    cyc(1'b0, 1'b0, 0, 4'h0, 32'h0, {32'h0, 32'h0000_0F0F, 64'h0}, 1'b1, g, e, v);
    rd(2, 4'hF, 32'h0000_0F0F, "R5 set");
    wr(2, 4'h1, 32'h0000_0003, '0);
    rd(2, 4'hF, 32'h0000_0F0C, "R4 clear");
    wr(2, 4'h3, 32'h0000_0F0F, {32'h0, 32'h0000_0100, 64'h0});
    rd(2, 4'hF, 32'h0000_0100, "R5 set wins");
    wr(2, 4'h3, 32'h0000_0000, '0);
    rd(2, 4'hF, 32'h0000_0100, "R4 zero no effect");
    wr(2, 4'hC, 32'hAA55_0000, '0);
    rd(2, 4'hF, 32'hAA55_0100, "R2 upper");

    // R7: soft reset
    cyc(1'b0, 1'b0, 0, 4'h0, 32'h0, '0, 1'b0, g, e, v);
    rd(2, 4'hF, 32'hAA00_0100, "R7 status");
    rd(1, 4'hF, 32'h3CAB_A500, "R7 control");
    rd(0, 4'hF, 32'h0000_0000, "R7 pointer");
    wr(1, 4'h4, 32'h0077_0000, '0);
    rd(1, 4'hF, 32'h3CAB_A500, "R7 flag kept");

    // R8: power-good reset clears flags
    pg_reset();
    rd(2, 4'hF, 32'h0000_0000, "R8 status");
    wr(1, 4'h4, 32'h0077_0000, '0);
    rd(1, 4'hF, 32'h3C77_A500, "R8 flag cleared");

    // random mix against the model
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 16);
      int a  = int'($urandom % 4);
      logic [3:0] b = bsel[$urandom % 8];
      logic [31:0] d = $urandom;
      logic [127:0] ev = '0;
      if ($urandom % 3 == 0)
        ev = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom}
           & {$urandom, $urandom, $urandom, $urandom};
      if (op < 6) begin
        cyc(1'b1, 1'b0, a, b, d, ev, 1'b1, g, e, v);
      end else if (op < 14) begin
        cyc(op[0], 1'b1, a, b, d, ev, 1'b1, g, e, v);
        chk("R2 random read", g, e);
      end else if (op == 14) begin
        cyc(1'b0, 1'b0, a, b, d, ev, 1'b1, g, e, v);
      end else begin
        cyc(1'b0, 1'b0, a, b, d, ev, 1'b0, g, e, v);
      end
    end
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b1, i, 4'hF, 32'h0, '0, 1'b1, g, e, v);
      chk("R7 final sweep", g, e);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule